// File: doc/BRIEF.md
# Segmented Scan Chain Controller

This controller runs a two-pattern delay test on a scan chain that is split into several segments. All segments share one scan-in wire and one scan-out wire. The controller clocks one segment at a time while the first vector is shifted in. The same shift moves the previous response out. While a segment shifts, only that segment drives the shared scan-out line.

After the load, the controller leaves shift mode and applies one launch cycle and then one capture cycle. Each of these cycles clocks only the segments named in its own mask, so launch and capture can go to different sets of segments. For example, a launch from segment 0 followed by a capture into segment 1 makes the second vector out of segment 0's captured values and segment 1's shifted values. Clocking every active segment in both cycles behaves like one long chain. After the capture, the response is shifted out segment by segment, again from the lowest index upward.

Before a test starts, the user sets the number of segments in use, the length of each segment, and the two masks. The controller takes a copy of all of these when it accepts a start. If a start arrives with a mask that is empty or an invalid segment count, the controller refuses it and raises an error flag instead.

Top module: `seg_scan_ctrl`

## Requirements
- R1: During reset and just after it, every output is 0: `seg_clk_en`, `seg_so_en`, `scan_en`, `busy`, `done` and `cfg_err`.
- R2: An accepted start is taken at a clock edge, and the load phase begins in the next cycle. Segments 0 to `seg_count`-1 are served in ascending order. Segment i shifts for (field i of `seg_len_m1`)+1 cycles, where field i is bits [i*LEN_W +: LEN_W]. During those cycles bit i is the only bit set in `seg_clk_en` and in `seg_so_en`, and `scan_en` is 1.
- R3: The load is followed by exactly one launch cycle. In it `scan_en` is 0, `seg_so_en` is 0, and `seg_clk_en` equals the launch mask ANDed with the active-segment mask, where bits 0 to `seg_count`-1 are active.
- R4: The launch cycle is followed by exactly one capture cycle. In it `scan_en` is 0, `seg_so_en` is 0, and `seg_clk_en` equals the capture mask ANDed with the active-segment mask.
- R5: After the capture, the unload phase repeats the shift pattern of R2. Then `done` is 1 for one cycle with all gating outputs at 0, and after that the block is idle with `busy` at 0. `busy` is 1 from the first load cycle through the `done` cycle.
- R6: A start is refused in three cases: the active launch mask is empty, the active capture mask is empty, or `seg_count` is 0 or greater than NUM_SEG. A refused start leaves the block idle, with no gating output set, and `cfg_err` reads 1 from the next cycle. `cfg_err` goes back to 0 at the next accepted start.
- R7: The copy of the segment count, lengths and masks is taken when a start is accepted. Changing these inputs during a run does not change the run's output sequence.
- R8: A start that arrives while `busy` is 1, including in the `done` cycle, is ignored. The block returns to idle and does not start a new run.
- R9: When both masks cover every active segment, every active segment is clocked in the launch cycle and again in the capture cycle, which matches an unsegmented chain.
- R10: Disjoint masks work. With launch mask 0001 and capture mask 0010, only segment 0 is clocked in the launch cycle and only segment 1 in the capture cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to start a test; acted on only while idle |
| seg_count | input | $clog2(NUM_SEG+1) | Number of segments in use (1..NUM_SEG) |
| seg_len_m1 | input | NUM_SEG*LEN_W | Per-segment length minus one, field i at [i*LEN_W +: LEN_W] |
| launch_mask | input | NUM_SEG | Segments that receive the launch pulse |
| capture_mask | input | NUM_SEG | Segments that receive the capture pulse |
| seg_clk_en | output | NUM_SEG | Per-segment clock enable |
| seg_so_en | output | NUM_SEG | Per-segment enable onto the shared scan-out line |
| scan_en | output | 1 | Shared scan enable (1 = shift) |
| busy | output | 1 | A test is in progress |
| done | output | 1 | One-cycle pulse at the end of the unload |
| cfg_err | output | 1 | The last start was refused |

## Verification
Two events can fall in the same cycle: a new start request, and the final `done` cycle of the run already in progress. The bench provokes this by raising `start` exactly in the `done` cycle while the configuration inputs are still valid. It then requires two idle cycles with no gating outputs, which shows that the request was ignored and not queued. In the same way, the configuration inputs are overwritten in the cycle after an accepted start, while the load is running. The bench judges this by comparing every cycle of the run against the sequence it built from the values present at the start.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_LOAD    = 3'd1,
        PH_LAUNCH  = 3'd2,
        PH_CAPTURE = 3'd3,
        PH_UNLOAD  = 3'd4,
        PH_DONE    = 3'd5
    } phase_e;

endpackage

// File: rtl/ssc_cfg_check.sv
module ssc_cfg_check #(
    parameter int NUM_SEG = 4,
    parameter int CNT_W   = 3
) (
    input  logic [CNT_W-1:0]   seg_count,
    input  logic [NUM_SEG-1:0] launch_mask,
    input  logic [NUM_SEG-1:0] capture_mask,
    output logic [NUM_SEG-1:0] lm_eff,
    output logic [NUM_SEG-1:0] cm_eff,
    output logic               cfg_ok
);
    logic [NUM_SEG-1:0] act_mask;
    logic               count_ok;

    // A segment is active when its index is below the programmed count.
    for (genvar i = 0; i < NUM_SEG; i++) begin : g_act
        assign act_mask[i] = (CNT_W'(i) < seg_count);
    end

    assign lm_eff   = launch_mask & act_mask;
    assign cm_eff   = capture_mask & act_mask;
    assign count_ok = (seg_count != '0) && (seg_count <= CNT_W'(NUM_SEG));
    assign cfg_ok   = count_ok && (|lm_eff) && (|cm_eff);

endmodule

// File: rtl/ssc_sequencer.sv
module ssc_sequencer
    import ssc_pkg::*;
#(
    parameter int NUM_SEG = 4,
    parameter int LEN_W   = 4,
    parameter int CNT_W   = 3,
    parameter int SEG_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     cfg_ok,
    input  logic [CNT_W-1:0]         seg_count,
    input  logic [NUM_SEG*LEN_W-1:0] seg_len_m1,
    input  logic [NUM_SEG-1:0]       lm_eff,
    input  logic [NUM_SEG-1:0]       cm_eff,
    output phase_e                   phase_o,
    output logic [SEG_W-1:0]         seg_o,
    output logic [NUM_SEG-1:0]       lm_o,
    output logic [NUM_SEG-1:0]       cm_o,
    output logic                     err_o
);
    typedef struct packed {
        phase_e                          phase;
        logic [SEG_W-1:0]                seg;
        logic [LEN_W-1:0]                cnt;
        logic [NUM_SEG-1:0][LEN_W-1:0]   lens;
        logic [CNT_W-1:0]                nseg;
        logic [NUM_SEG-1:0]              lm;
        logic [NUM_SEG-1:0]              cm;
        logic                            err;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [NUM_SEG-1:0][LEN_W-1:0] lens_in;
    logic                          last_seg;
    logic                          len_hit;
    logic                          shifting;

    assign lens_in  = seg_len_m1;
    assign shifting = (seq_q.phase == PH_LOAD) || (seq_q.phase == PH_UNLOAD);
    assign last_seg = ((CNT_W'(seq_q.seg) + CNT_W'(1)) == seq_q.nseg);
    assign len_hit  = (seq_q.cnt == seq_q.lens[seq_q.seg]);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start) begin
                    if (cfg_ok) begin
                        seq_d.phase = PH_LOAD;
                        seq_d.seg   = '0;
                        seq_d.cnt   = '0;
                        seq_d.lens  = lens_in;
                        seq_d.nseg  = seg_count;
                        seq_d.lm    = lm_eff;
                        seq_d.cm    = cm_eff;
                        seq_d.err   = 1'b0;
                    end else begin
                        seq_d.err   = 1'b1;
                    end
                end
            end
            PH_LOAD, PH_UNLOAD: begin
                if (len_hit) begin
                    seq_d.cnt = '0;
                    if (last_seg) begin
                        seq_d.seg   = '0;
                        seq_d.phase = (seq_q.phase == PH_LOAD) ? PH_LAUNCH : PH_DONE;
                    end else begin
                        seq_d.seg = seq_q.seg + SEG_W'(1);
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + LEN_W'(1);
                end
            end
            PH_LAUNCH:  seq_d.phase = PH_CAPTURE;
            PH_CAPTURE: begin
                seq_d.phase = PH_UNLOAD;
                seq_d.seg   = '0;
                seq_d.cnt   = '0;
            end
            PH_DONE:    seq_d.phase = PH_IDLE;
            default:    seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign phase_o = seq_q.phase;
    assign seg_o   = seq_q.seg;
    assign lm_o    = seq_q.lm;
    assign cm_o    = seq_q.cm;
    assign err_o   = seq_q.err;

    // R4
    launch_then_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_LAUNCH) |=> (seq_q.phase == PH_CAPTURE));

    // R2
    shift_within_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shifting |-> (seq_q.cnt <= seq_q.lens[seq_q.seg]));

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && seq_q.phase != PH_IDLE) |=> ($stable(seq_q.lm) && $stable(seq_q.cm) && $stable(seq_q.nseg)));

endmodule

// File: rtl/ssc_gate_decode.sv
module ssc_gate_decode
    import ssc_pkg::*;
#(
    parameter int NUM_SEG = 4,
    parameter int SEG_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  phase_e                 phase,
    input  logic [SEG_W-1:0]       seg,
    input  logic [NUM_SEG-1:0]     lm,
    input  logic [NUM_SEG-1:0]     cm,
    output logic [NUM_SEG-1:0]     seg_clk_en,
    output logic [NUM_SEG-1:0]     seg_so_en,
    output logic                   scan_en
);
    logic shifting;

    assign shifting = (phase == PH_LOAD) || (phase == PH_UNLOAD);
    assign scan_en  = shifting;

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        logic addressed;
        assign addressed     = shifting && (seg == SEG_W'(i));
        assign seg_so_en[i]  = addressed;
        assign seg_clk_en[i] = addressed
                             || ((phase == PH_LAUNCH)  && lm[i])
                             || ((phase == PH_CAPTURE) && cm[i]);
    end

    // R2
    so_single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seg_so_en));

    // R3
    launch_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAUNCH) |-> (!scan_en && seg_so_en == '0));

endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
    import ssc_pkg::*;
#(
    parameter int NUM_SEG = 4,
    parameter int LEN_W   = 4,
    localparam int CNT_W  = $clog2(NUM_SEG + 1),
    localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CNT_W-1:0]         seg_count,
    input  logic [NUM_SEG*LEN_W-1:0] seg_len_m1,
    input  logic [NUM_SEG-1:0]       launch_mask,
    input  logic [NUM_SEG-1:0]       capture_mask,
    output logic [NUM_SEG-1:0]       seg_clk_en,
    output logic [NUM_SEG-1:0]       seg_so_en,
    output logic                     scan_en,
    output logic                     busy,
    output logic                     done,
    output logic                     cfg_err
);
    logic [NUM_SEG-1:0] lm_eff, cm_eff, lm_q, cm_q;
    logic               cfg_ok;
    phase_e             phase;
    logic [SEG_W-1:0]   seg;

    ssc_cfg_check #(.NUM_SEG(NUM_SEG), .CNT_W(CNT_W)) u_check (
        .seg_count    (seg_count),
        .launch_mask  (launch_mask),
        .capture_mask (capture_mask),
        .lm_eff       (lm_eff),
        .cm_eff       (cm_eff),
        .cfg_ok       (cfg_ok)
    );

    ssc_sequencer #(.NUM_SEG(NUM_SEG), .LEN_W(LEN_W), .CNT_W(CNT_W), .SEG_W(SEG_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_ok     (cfg_ok),
        .seg_count  (seg_count),
        .seg_len_m1 (seg_len_m1),
        .lm_eff     (lm_eff),
        .cm_eff     (cm_eff),
        .phase_o    (phase),
        .seg_o      (seg),
        .lm_o       (lm_q),
        .cm_o       (cm_q),
        .err_o      (cfg_err)
    );

    ssc_gate_decode #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .seg        (seg),
        .lm         (lm_q),
        .cm         (cm_q),
        .seg_clk_en (seg_clk_en),
        .seg_so_en  (seg_so_en),
        .scan_en    (scan_en)
    );

    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_DONE);

    // R6
    err_keeps_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (seg_clk_en == '0 && !busy));

    // R5
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

// File: tb/seg_scan_ctrl_tb_top.sv
module seg_scan_ctrl_tb_top;
    localparam int NS = 4;
    localparam int LW = 4;

    typedef struct packed {
        logic [NS-1:0] clk_en;
        logic [NS-1:0] so_en;
        logic          se;
        logic          busy;
        logic          done;
        logic          err;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        seg_count = '0;
    logic [NS*LW-1:0]  seg_len_m1 = '0;
    logic [NS-1:0]     launch_mask = '0;
    logic [NS-1:0]     capture_mask = '0;
    logic [NS-1:0]     seg_clk_en, seg_so_en;
    logic              scan_en, busy, done, cfg_err;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    item_t exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    seg_scan_ctrl #(.NUM_SEG(NS), .LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .seg_count(seg_count),
        .seg_len_m1(seg_len_m1), .launch_mask(launch_mask), .capture_mask(capture_mask),
        .seg_clk_en(seg_clk_en), .seg_so_en(seg_so_en), .scan_en(scan_en),
        .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    function automatic item_t mk(logic [NS-1:0] c, logic [NS-1:0] s, logic se,
                                 logic b, logic d, logic e);
        item_t it;
        it.clk_en = c; it.so_en = s; it.se = se; it.busy = b; it.done = d; it.err = e;
        return it;
    endfunction

    function automatic item_t actual();
        return mk(seg_clk_en, seg_so_en, scan_en, busy, done, cfg_err);
    endfunction

    task automatic push(item_t it, string tag);
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    // Monitor: pops one expected item per cycle, away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = actual();
            checks++;
            if (a !== e) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Driver for an accepted run: pushes the full expected sequence.
    task automatic run_pat(int cnt, logic [NS*LW-1:0] lens, logic [NS-1:0] lm,
                           logic [NS-1:0] cm, bit stray, bit scramble,
                           string tag_sh, string tag_lc);
        logic [NS-1:0] act;
        int k;
        act = NS'((1 << cnt) - 1);
        @(negedge clk);
        seg_count = 3'(cnt); seg_len_m1 = lens; launch_mask = lm; capture_mask = cm;
        start = 1'b1;
        @(posedge clk);
        #1;
        k = 0;
        for (int s = 0; s < cnt; s++)
            for (int c = 0; c <= int'(lens[s*LW +: LW]); c++) begin
                push(mk(NS'(1 << s), NS'(1 << s), 1'b1, 1'b1, 1'b0, 1'b0), tag_sh); k++;
            end
        push(mk(lm & act, '0, 1'b0, 1'b1, 1'b0, 1'b0), tag_lc); k++;
        push(mk(cm & act, '0, 1'b0, 1'b1, 1'b0, 1'b0), tag_lc); k++;
        for (int s = 0; s < cnt; s++)
            for (int c = 0; c <= int'(lens[s*LW +: LW]); c++) begin
                push(mk(NS'(1 << s), NS'(1 << s), 1'b1, 1'b1, 1'b0, 1'b0), "R5"); k++;
            end
        push(mk('0, '0, 1'b0, 1'b1, 1'b1, 1'b0), "R5"); k++;
        push(mk('0, '0, 1'b0, 1'b0, 1'b0, 1'b0), stray ? "R8" : "R5");
        push(mk('0, '0, 1'b0, 1'b0, 1'b0, 1'b0), stray ? "R8" : "R5");
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            seg_count = 3'd1; seg_len_m1 = '1; launch_mask = '0; capture_mask = '0;
        end
        if (stray) begin
            repeat (k - 1) @(posedge clk);
            @(negedge clk);
            start = 1'b1;          // lands in the done cycle
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
        end
        drain();
    endtask

    // Driver for a refused start.
    task automatic run_err(int cnt, logic [NS-1:0] lm, logic [NS-1:0] cm);
        @(negedge clk);
        seg_count = 3'(cnt); seg_len_m1 = 16'h1111; launch_mask = lm; capture_mask = cm;
        start = 1'b1;
        @(posedge clk);
        #1;
        push(mk('0, '0, 1'b0, 1'b0, 1'b0, 1'b1), "R6");
        push(mk('0, '0, 1'b0, 1'b0, 1'b0, 1'b1), "R6");
        @(negedge clk);
        start = 1'b0;
        drain();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (actual() !== mk('0, '0, 1'b0, 1'b0, 1'b0, 1'b0)) begin
            failures++;
            $display("FAIL R1 actual=%h expected=%h", actual(), mk('0, '0, 1'b0, 1'b0, 1'b0, 1'b0));
        end
        rst_n = 1'b1;
        // R2 R10: disjoint launch/capture, lengths 3,1,4,2 cells
        run_pat(4, {4'd1, 4'd3, 4'd0, 4'd2}, 4'b0001, 4'b0010, 1'b0, 1'b0, "R2", "R10");
        // R9: all segments launch and capture
        run_pat(4, {4'd0, 4'd1, 4'd0, 4'd1}, 4'b1111, 4'b1111, 1'b0, 1'b0, "R2", "R9");
        // R3 R4: mask bits above the count are dropped
        run_pat(2, {4'd7, 4'd7, 4'd2, 4'd1}, 4'b1101, 4'b1010, 1'b0, 1'b0, "R2", "R3 R4");
        // R6: refused starts
        run_err(3, 4'b0000, 4'b0011);
        run_err(2, 4'b1000, 4'b0001);
        run_err(0, 4'b0001, 4'b0001);
        run_err(5, 4'b0001, 4'b0001);
        // R6 R7: accepted start clears the error; inputs overwritten mid-run
        run_pat(3, {4'd0, 4'd0, 4'd1, 4'd2}, 4'b0110, 4'b0101, 1'b0, 1'b1, "R7", "R7");
        // R8: start raised in the done cycle is ignored
        run_pat(1, {4'd0, 4'd0, 4'd0, 4'd3}, 4'b0001, 4'b0001, 1'b1, 1'b0, "R2", "R4");
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule